// File: doc/BRIEF.md
# Load-Exclusive Execution Unit

This unit carries out a single load-exclusive operation for a small processor data path. When `start` is raised it adds two register operands to form the effective address and issues one full-word read. It then resolves three possible faults in a fixed order: a translation miss, a zone-protection denial and a failed exclusive bus access. If none of them applies, the loaded word leaves through a destination write port, the reservation bit is set, and the carry flag records whether the bus refused exclusivity. If a fault is taken, the unit updates the exception cause and indicator bits and, for the two memory-management faults, saves and clears the live mode bits.

The sequencer is a three-state machine. **S_IDLE** waits for `start`. **S_ADDR** is visited only in the small-area build and holds the cycle in which the shared adder produces the address. **S_RESOLVE** presents the read and samples the side-band flags and the response. Its transitions are: *T_ISSUE_FAST* (S_IDLE→S_RESOLVE on `start`, fast build), *T_ISSUE_SMALL* (S_IDLE→S_ADDR on `start`, small build), *T_ADDR_DONE* (S_ADDR→S_RESOLVE, unconditional) and *T_RETIRE* (S_RESOLVE→S_IDLE, unconditional, with results committed on that edge). The translation-miss flag, the zone flag, the exclusive-region flag, the read data and the exclusive-okay response are sampled only in S_RESOLVE. The caller holds them stable from `start` until `done`.

A load port writes the whole mode and status word, so a caller can set up modes before an operation. A separate input drops the reservation bit, which models the paired store-exclusive consuming it. Status word layout (`status` and `ctl_wdata`): bit 0 user mode, bit 1 virtual mode, bit 2 saved user mode, bit 3 saved virtual mode, bit 4 exception enable, bit 5 carry, bit 6 store indicator, bit 7 ECC indicator, bit 8 zone indicator.

Top module: `ldx_unit`

## Requirements
- R1: `mem_addr` equals `src_a + src_b` (modulo 2^32) while `mem_req` is high, and a non-zero value in the two low address bits never causes an exception.
- R2: With `SMALL_AREA=0`, `mem_req` is high in the first cycle after the edge that samples `start` and `done` is high in the second. With `SMALL_AREA=1`, each of these moves one cycle later. `done` lasts exactly one cycle, and `exc_taken` is only ever high together with `done`.
- R3: A translation miss while virtual mode is on has the highest priority. It writes cause 5'b10010 to `esr_ec`, clears the store indicator, copies user and virtual mode into their saved bits and clears both live bits. With virtual mode off, the miss flag has no effect.
- R4: Otherwise, a zone denial while both user and virtual mode are on writes cause 5'b10000, clears the store indicator, sets the zone indicator and saves and clears the mode bits as in R3.
- R5: Otherwise, an exclusive access that is answered without exclusive-okay while exception enable is on writes cause 5'b00100 and clears the ECC indicator. This fault leaves all four mode bits unchanged.
- R6: When no fault is taken, `rd_we` pulses with `done`, `rd_sel` equals the `dst_sel` given at `start`, `rd_data` equals the read data, and the reservation bit becomes 1.
- R7: When no fault is taken, carry becomes 1 if the access was exclusive and the response lacked exclusive-okay, and 0 in every other case, including every non-exclusive access.
- R8: When a fault is taken, `rd_we` stays low and carry keeps its previous value.
- R9: With `EXCL_BUS=0`, every access is treated as non-exclusive: the bus fault is never raised and a completed operation always clears carry.
- R10: `ctl_wr` loads the whole status word and `resv_clr` clears the reservation bit, each taking effect on the next edge. On the edge where an operation retires, the commit takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one load-exclusive operation (taken in S_IDLE) |
| src_a | input | 32 | First address operand |
| src_b | input | 32 | Second address operand |
| dst_sel | input | 5 | Destination register index |
| tlb_miss | input | 1 | No valid translation for the address |
| zone_deny | input | 1 | Zone protection forbids the access |
| excl_region | input | 1 | The addressed slave takes part in exclusive access |
| mem_req | output | 1 | Word read request (S_RESOLVE) |
| mem_addr | output | 32 | Word read address |
| mem_rdata | input | 32 | Read data |
| mem_exokay | input | 1 | Response was exclusive-okay |
| ctl_wr | input | 1 | Load the status word |
| ctl_wdata | input | 9 | Status word to load |
| resv_clr | input | 1 | Clear the reservation bit |
| status | output | 9 | Mode and status bits |
| esr_ec | output | 5 | Exception cause code |
| resv | output | 1 | Reservation bit |
| rd_we | output | 1 | Destination write strobe |
| rd_sel | output | 5 | Destination register index |
| rd_data | output | 32 | Destination write data |
| done | output | 1 | Operation retired (one cycle) |
| exc_taken | output | 1 | The retired operation raised a fault |

## Verification
The bench drives two copies side by side with identical stimulus. One uses `SMALL_AREA=0, EXCL_BUS=1`, which covers the one-cycle path, carry being set by a refused exclusive access, and the bus fault. The other uses `SMALL_AREA=1, EXCL_BUS=0`, which covers the extra address cycle and shows that the same refused response clears carry and never faults when exclusive signalling is disabled. The two builds are compared every cycle with a behavioural model of each, so the differences in latency and in the bus outcome are checked on the same operations.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ADDR    = 2'd1,
        S_RESOLVE = 2'd2
    } ldx_state_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_TLB  = 2'd1,
        EXC_PROT = 2'd2,
        EXC_BUS  = 2'd3
    } exc_kind_e;

    localparam logic [4:0] EC_TLB  = 5'b10010;
    localparam logic [4:0] EC_PROT = 5'b10000;
    localparam logic [4:0] EC_BUS  = 5'b00100;

    localparam int CTL_W = 9;

    // Bit 0 is user mode, bit 8 is the zone indicator.
    typedef struct packed {
        logic diz;
        logic ecc;
        logic s;
        logic carry;
        logic ee;
        logic vms;
        logic ums;
        logic vm;
        logic um;
    } ctl_t;

endpackage

// File: rtl/ldx_addr_gen.sv
// Effective address generator. The fast variant adds while the operands
// are presented. The small variant latches the operands and adds in the
// following cycle, so the adder sits off the operand-bypass path.
module ldx_addr_gen #(
    parameter int DATA_W     = 32,
    parameter bit SMALL_AREA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] addr
);

    logic [DATA_W-1:0] addr_q;

    generate
        if (SMALL_AREA) begin : g_small
            logic [DATA_W-1:0] a_q;
            logic [DATA_W-1:0] b_q;
            logic              pend_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    a_q    <= '0;
                    b_q    <= '0;
                    pend_q <= 1'b0;
                    addr_q <= '0;
                end else begin
                    pend_q <= load;
                    if (load) begin
                        a_q <= op_a;
                        b_q <= op_b;
                    end
                    if (pend_q) begin
                        addr_q <= a_q + b_q;
                    end
                end
            end
        end else begin : g_fast
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (load) begin
                    addr_q <= op_a + op_b;
                end
            end
        end
    endgenerate

    assign addr = addr_q;

endmodule

// File: rtl/ldx_prio.sv
// Fault priority resolver: translation miss, then zone denial, then
// refused exclusive access. Purely combinational.
module ldx_prio
    import ldx_pkg::*;
#(
    parameter bit EXCL_BUS = 1'b1
) (
    input  logic      tlb_miss,
    input  logic      zone_deny,
    input  logic      excl_region,
    input  logic      exokay,
    input  logic      um,
    input  logic      vm,
    input  logic      ee,
    output exc_kind_e kind,
    output logic      excl_fail
);

    localparam logic EXCL_ON = EXCL_BUS;

    logic excl_eff;
    logic tlb_hit;
    logic prot_hit;
    logic bus_hit;

    always_comb begin
        excl_eff  = excl_region & EXCL_ON;
        excl_fail = excl_eff & ~exokay;
        tlb_hit   = tlb_miss & vm;
        prot_hit  = zone_deny & um & vm;
        bus_hit   = excl_fail & ee;

        if (tlb_hit) begin
            kind = EXC_TLB;
        end else if (prot_hit) begin
            kind = EXC_PROT;
        end else if (bus_hit) begin
            kind = EXC_BUS;
        end else begin
            kind = EXC_NONE;
        end
    end

endmodule

// File: rtl/ldx_status.sv
// Architectural state touched by the operation: status word, cause code,
// reservation bit and the destination write port.
module ldx_status
    import ldx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RSEL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  exc_kind_e         kind,
    input  logic              excl_fail,
    input  logic [DATA_W-1:0] load_data,
    input  logic [RSEL_W-1:0] load_sel,
    input  logic              ctl_wr,
    input  ctl_t              ctl_wdata,
    input  logic              resv_clr,
    output ctl_t              ctl,
    output logic [4:0]        ec,
    output logic              resv,
    output logic              rd_we,
    output logic [RSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    ctl_t              ctl_q;
    logic [4:0]        ec_q;
    logic              resv_q;
    logic              we_q;
    logic [RSEL_W-1:0] sel_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            ec_q   <= '0;
            resv_q <= 1'b0;
            we_q   <= 1'b0;
            sel_q  <= '0;
            data_q <= '0;
        end else begin
            we_q <= 1'b0;
            if (commit) begin
                unique case (kind)
                    EXC_TLB: begin
                        ec_q      <= EC_TLB;
                        ctl_q.s   <= 1'b0;
                        ctl_q.ums <= ctl_q.um;
                        ctl_q.vms <= ctl_q.vm;
                        ctl_q.um  <= 1'b0;
                        ctl_q.vm  <= 1'b0;
                    end
                    EXC_PROT: begin
                        ec_q      <= EC_PROT;
                        ctl_q.s   <= 1'b0;
                        ctl_q.diz <= 1'b1;
                        ctl_q.ums <= ctl_q.um;
                        ctl_q.vms <= ctl_q.vm;
                        ctl_q.um  <= 1'b0;
                        ctl_q.vm  <= 1'b0;
                    end
                    EXC_BUS: begin
                        ec_q      <= EC_BUS;
                        ctl_q.ecc <= 1'b0;
                    end
                    EXC_NONE: begin
                        ctl_q.carry <= excl_fail;
                        resv_q      <= 1'b1;
                        we_q        <= 1'b1;
                        sel_q       <= load_sel;
                        data_q      <= load_data;
                    end
                    default: ;
                endcase
            end else begin
                if (ctl_wr) begin
                    ctl_q <= ctl_wdata;
                end
                if (resv_clr) begin
                    resv_q <= 1'b0;
                end
            end
        end
    end

    assign ctl     = ctl_q;
    assign ec      = ec_q;
    assign resv    = resv_q;
    assign rd_we   = we_q;
    assign rd_sel  = sel_q;
    assign rd_data = data_q;

endmodule

// File: rtl/ldx_unit.sv
// Load-exclusive execution unit: sequencer plus address, priority and
// status sub-blocks.
module ldx_unit
    import ldx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RSEL_W     = 5,
    parameter bit SMALL_AREA = 1'b0,
    parameter bit EXCL_BUS   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [RSEL_W-1:0] dst_sel,
    input  logic              tlb_miss,
    input  logic              zone_deny,
    input  logic              excl_region,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_exokay,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              resv_clr,
    output logic [CTL_W-1:0]  status,
    output logic [4:0]        esr_ec,
    output logic              resv,
    output logic              rd_we,
    output logic [RSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              exc_taken
);

    localparam ldx_state_e ISSUE_TARGET = SMALL_AREA ? S_ADDR : S_RESOLVE;

    ldx_state_e        state_q;
    ldx_state_e        state_d;
    logic              issue;
    logic              resolving;
    logic [RSEL_W-1:0] sel_q;
    logic              done_q;
    logic              exc_q;
    exc_kind_e         kind;
    logic              excl_fail;
    ctl_t              ctl;

    assign issue     = (state_q == S_IDLE) && start;
    assign resolving = (state_q == S_RESOLVE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions T_ISSUE_FAST / T_ISSUE_SMALL, T_ADDR_DONE, T_RETIRE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = ISSUE_TARGET;
            S_ADDR:    state_d = S_RESOLVE;
            S_RESOLVE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Registered outputs of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            done_q <= 1'b0;
            exc_q  <= 1'b0;
        end else begin
            if (issue) begin
                sel_q <= dst_sel;
            end
            done_q <= resolving;
            exc_q  <= resolving && (kind != EXC_NONE);
        end
    end

    ldx_addr_gen #(
        .DATA_W     (DATA_W),
        .SMALL_AREA (SMALL_AREA)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (issue),
        .op_a  (src_a),
        .op_b  (src_b),
        .addr  (mem_addr)
    );

    ldx_prio #(
        .EXCL_BUS (EXCL_BUS)
    ) u_prio (
        .tlb_miss    (tlb_miss),
        .zone_deny   (zone_deny),
        .excl_region (excl_region),
        .exokay      (mem_exokay),
        .um          (ctl.um),
        .vm          (ctl.vm),
        .ee          (ctl.ee),
        .kind        (kind),
        .excl_fail   (excl_fail)
    );

    ldx_status #(
        .DATA_W (DATA_W),
        .RSEL_W (RSEL_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (resolving),
        .kind      (kind),
        .excl_fail (excl_fail),
        .load_data (mem_rdata),
        .load_sel  (sel_q),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_t'(ctl_wdata)),
        .resv_clr  (resv_clr),
        .ctl       (ctl),
        .ec        (esr_ec),
        .resv      (resv),
        .rd_we     (rd_we),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    assign mem_req   = resolving;
    assign status    = ctl;
    assign done      = done_q;
    assign exc_taken = exc_q;

endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
    parameter bit EXCL_BUS = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_req,
    input logic       done,
    input logic       exc_taken,
    input logic       rd_we,
    input logic [8:0] status,
    input logic [4:0] esr_ec,
    input logic       resv
);

    assert_req_then_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_exc_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> done);

    assert_tlb_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && esr_ec == 5'b10010) |-> (status[3] && !status[1] && !status[0] && !status[6]));

    assert_prot_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && esr_ec == 5'b10000)
        |-> (status[2] && status[3] && !status[0] && !status[1] && status[8] && !status[6]));

    assert_bus_modes_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && esr_ec == 5'b00100)
        |-> (status[3:0] == $past(status[3:0]) && $past(status[4]) && !status[7]));

    assert_write_reserves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (done && !exc_taken && resv));

    assert_fault_holds_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (status[5] == $past(status[5]) && !rd_we));

    generate
        if (!EXCL_BUS) begin : g_no_excl
            assert_no_excl_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (done && !exc_taken) |-> !status[5]);

            assert_no_bus_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
                exc_taken |-> (esr_ec != 5'b00100));
        end
    endgenerate

endmodule

bind ldx_unit ldx_unit_chk #(
    .EXCL_BUS (EXCL_BUS)
) u_ldx_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .done      (done),
    .exc_taken (exc_taken),
    .rd_we     (rd_we),
    .status    (status),
    .esr_ec    (esr_ec),
    .resv      (resv)
);

// File: tb/test_ldx_unit.sv
module test_ldx_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic [RW-1:0] dst_sel = '0;
    logic          in_tlb = 1'b0;
    logic          in_zone = 1'b0;
    logic          in_excl = 1'b0;
    logic [DW-1:0] in_rdata = '0;
    logic          in_exok = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [8:0]    ctl_wdata = '0;
    logic          resv_clr = 1'b0;

    logic          p_req, s_req, p_we, s_we, p_done, s_done, p_exc, s_exc, p_resv, s_resv;
    logic [DW-1:0] p_addr, s_addr, p_rdata, s_rdata;
    logic [8:0]    p_st, s_st;
    logic [4:0]    p_ec, s_ec, p_sel, s_sel;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ldx_unit #(.DATA_W(DW), .RSEL_W(RW), .SMALL_AREA(1'b0), .EXCL_BUS(1'b1)) i_ldx_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .dst_sel(dst_sel), .tlb_miss(in_tlb), .zone_deny(in_zone), .excl_region(in_excl),
        .mem_req(p_req), .mem_addr(p_addr), .mem_rdata(in_rdata), .mem_exokay(in_exok),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .resv_clr(resv_clr), .status(p_st),
        .esr_ec(p_ec), .resv(p_resv), .rd_we(p_we), .rd_sel(p_sel), .rd_data(p_rdata),
        .done(p_done), .exc_taken(p_exc));

    ldx_unit #(.DATA_W(DW), .RSEL_W(RW), .SMALL_AREA(1'b1), .EXCL_BUS(1'b0)) i_ldx_unit_small (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .dst_sel(dst_sel), .tlb_miss(in_tlb), .zone_deny(in_zone), .excl_region(in_excl),
        .mem_req(s_req), .mem_addr(s_addr), .mem_rdata(in_rdata), .mem_exokay(in_exok),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .resv_clr(resv_clr), .status(s_st),
        .esr_ec(s_ec), .resv(s_resv), .rd_we(s_we), .rd_sel(s_sel), .rd_data(s_rdata),
        .done(s_done), .exc_taken(s_exc));

    int checks = 0;
    int errors = 0;

    // Behavioural model state: status word, cause code, reservation.
    typedef struct packed {
        logic [8:0] st;
        logic [4:0] ec;
        logic       resv;
    } mdl_t;

    mdl_t      mp = '0;
    mdl_t      ms = '0;
    logic [1:0] e_req = '0;
    logic [1:0] e_done = '0;
    logic [1:0] e_we = '0;
    logic [1:0] e_exc = '0;
    logic [DW-1:0] exp_addr = '0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic mdl_t step(input mdl_t m, input logic excl_en, output logic took);
        logic ex;
        ex   = excl_en & in_excl;
        took = 1'b1;
        if (in_tlb && m.st[1]) begin
            m.ec    = 5'b10010;
            m.st[6] = 1'b0;
            m.st[2] = m.st[0];
            m.st[3] = m.st[1];
            m.st[0] = 1'b0;
            m.st[1] = 1'b0;
        end else if (in_zone && m.st[0] && m.st[1]) begin
            m.ec    = 5'b10000;
            m.st[6] = 1'b0;
            m.st[8] = 1'b1;
            m.st[2] = m.st[0];
            m.st[3] = m.st[1];
            m.st[0] = 1'b0;
            m.st[1] = 1'b0;
        end else if (ex && !in_exok && m.st[4]) begin
            m.ec    = 5'b00100;
            m.st[7] = 1'b0;
        end else begin
            took    = 1'b0;
            m.resv  = 1'b1;
            m.st[5] = ex && !in_exok;
        end
        return m;
    endfunction

    // One cycle: compare both builds against their models at the falling edge.
    task automatic tick();
        @(negedge clk);
        chk("R3/R4/R5 status fast", {23'd0, p_st}, {23'd0, mp.st});
        chk("R3/R4/R5 status small", {23'd0, s_st}, {23'd0, ms.st});
        chk("R3/R4/R5 cause fast", {27'd0, p_ec}, {27'd0, mp.ec});
        chk("R3/R4/R5 cause small", {27'd0, s_ec}, {27'd0, ms.ec});
        chk("R6 R10 resv fast", {31'd0, p_resv}, {31'd0, mp.resv});
        chk("R6 R10 resv small", {31'd0, s_resv}, {31'd0, ms.resv});
        chk("R2 req fast", {31'd0, p_req}, {31'd0, e_req[0]});
        chk("R2 req small", {31'd0, s_req}, {31'd0, e_req[1]});
        chk("R2 done fast", {31'd0, p_done}, {31'd0, e_done[0]});
        chk("R2 done small", {31'd0, s_done}, {31'd0, e_done[1]});
        chk("R8 exc fast", {31'd0, p_exc}, {31'd0, e_exc[0]});
        chk("R8 exc small", {31'd0, s_exc}, {31'd0, e_exc[1]});
        chk("R6 R8 we fast", {31'd0, p_we}, {31'd0, e_we[0]});
        chk("R6 R8 we small", {31'd0, s_we}, {31'd0, e_we[1]});
        if (e_req[0]) chk("R1 addr fast", p_addr, exp_addr);
        if (e_req[1]) chk("R1 addr small", s_addr, exp_addr);
        if (e_we[0]) begin
            chk("R6 data fast", p_rdata, in_rdata);
            chk("R6 sel fast", {27'd0, p_sel}, {27'd0, dst_sel});
        end
        if (e_we[1]) begin
            chk("R6 data small", s_rdata, in_rdata);
            chk("R6 sel small", {27'd0, s_sel}, {27'd0, dst_sel});
        end
    endtask

    task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [RW-1:0] sel,
                          input logic tlb, input logic zone, input logic excl, input logic exok,
                          input logic [DW-1:0] data);
        logic tp;
        logic ts;
        src_a = a; src_b = b; dst_sel = sel; in_tlb = tlb; in_zone = zone;
        in_excl = excl; in_exok = exok; in_rdata = data; exp_addr = a + b;
        start = 1'b1;
        e_req = 2'b01;
        tick();
        start = 1'b0;
        mp = step(mp, 1'b1, tp);
        e_req = 2'b10; e_done = 2'b01; e_we = {1'b0, ~tp}; e_exc = {1'b0, tp};
        tick();
        ms = step(ms, 1'b0, ts);
        e_req = 2'b00; e_done = 2'b10; e_we = {~ts, 1'b0}; e_exc = {ts, 1'b0};
        tick();
        e_done = 2'b00; e_we = 2'b00; e_exc = 2'b00;
        tick();
        in_tlb = 1'b0; in_zone = 1'b0; in_excl = 1'b0; in_exok = 1'b0;
    endtask

    task automatic load_ctl(input logic [8:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        mp.st = v; ms.st = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic drop_resv();
        resv_clr = 1'b1;
        mp.resv = 1'b0; ms.resv = 1'b0;
        tick();
        resv_clr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (CLK_PERIOD * 1000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R10 state word, R6 reservation).
        tick();

        // R10: load um, vm, ee.
        load_ctl(9'h013);
        // R1 unaligned sum, R6/R7 non-exclusive success clears carry.
        run_op(32'h0000_1001, 32'h0000_0002, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        // R7 exclusive with exclusive-okay: carry 0.
        run_op(32'hFFFF_FFFE, 32'h0000_0007, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5678);
        // R7 refused exclusive, faults disabled: fast sets carry, small (R9) clears it.
        load_ctl(9'h003);
        run_op(32'h0000_0100, 32'h0000_0020, 5'd9, 1'b0, 1'b0, 1'b1, 1'b0, 32'hCAFE_0001);
        // R5/R8 bus fault on fast keeps carry=1 and modes; R9 small completes.
        drop_resv();
        load_ctl(9'h0B3);
        run_op(32'h0000_2000, 32'h0000_0003, 5'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0BAD_F00D);
        // R3 translation miss beats zone and bus faults.
        load_ctl(9'h053);
        run_op(32'h4000_0000, 32'h0000_0010, 5'd2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h5555_AAAA);
        // R3 miss ignored with virtual mode off.
        run_op(32'h4000_0000, 32'h0000_0014, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 32'hAAAA_5555);
        // R4 zone denial beats bus fault.
        load_ctl(9'h053);
        run_op(32'h8000_0000, 32'h0000_0001, 5'd5, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0F0F_0F0F);
        // R4 zone ignored without user mode.
        load_ctl(9'h012);
        run_op(32'h8000_0000, 32'h8000_0000, 5'd31, 1'b0, 1'b1, 1'b1, 1'b1, 32'hF0F0_F0F0);
        // R10 reservation cleared by the store-exclusive input.
        drop_resv();
        tick();

        summary();
        $finish;
    end

endmodule